// File: doc/BRIEF.md
# UART Frame Engine

This block is the character-level core of a serial port. A baud generator outside the block supplies a `tick` pulse at 3 or 4 times the bit rate. The transmit side takes one byte at a time from a valid/ready handshake, normally the read port of a transmit FIFO. It sends the byte as a start bit, 5 to 8 data bits, an optional parity bit and one or two stop bits. The receive side watches the incoming line, finds start bits, and rebuilds each character. It raises sticky flags for parity and framing faults.

The frame format comes from a seven-bit slice, bits 21 down to 15, of the port's control word. The slice keeps its bit positions so that the register decode outside the block can pass the field straight through. The block reads each field as follows:

- The length code is inverted: a smaller code gives a longer character.
- Parity has an enable bit and a bit that selects odd or even parity.
- A two-bit stop field asks for a second stop bit.
- The lowest bit of the slice chooses two-wire operation. The block only reflects that choice back out as a flow-control enable for logic elsewhere.

Top module: `uart_frame_engine`

## Requirements
- R1: The length code in control bits 21:20 selects the data width: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. The same width applies to both directions, and received characters shorter than 8 bits are zero-extended on `rxData`.
- R2: Control bit 19 adds a parity bit after the data bits. Control bit 18 selects the sense of that bit: 1 makes the count of ones over data and parity odd, and 0 makes it even. The transmitter generates the bit and the receiver checks it.
- R3: The stop code in control bits 17:16 gives two stop bits when it equals 1. Any other value gives one stop bit. The receiver checks only the first stop bit.
- R4: `txLine` idles high. A frame starts with a low start bit, and data goes out least significant bit first. Every bit lasts OVERSAMPLE ticks.
- R5: `txReady` is high only while the transmitter is idle. A byte is taken on a clock edge where both `txValid` and `txReady` are high, and `txReady` is low in the cycle that follows.
- R6: `txBusy` rises in the cycle after a byte is accepted. It stays high until the last stop bit has been on the line for its full length, whether or not more bytes are offered.
- R7: After a falling edge on `rxLine`, the receiver samples again near the middle of the start bit. If the line is high there, the event is dropped as a false start and no character is delivered.
- R8: Each received character appears on `rxData` with `rxValid` high for exactly one cycle, shortly after the middle of its first stop bit.
- R9: A parity mismatch sets `parityErr`. The flag stays set through later good characters until it is cleared.
- R10: A low level at the first stop bit sets `frameErr`, and the character is still delivered. The flag is sticky.
- R11: Holding `errClear` high for a cycle clears both error flags. If an error is detected in the same cycle as the clear, that error is kept.
- R12: `flowCtlEn` is the inverse of control bit 15: it is high unless two-wire mode is selected.
- R13: After reset, `txLine` is high, `txReady` is high, and `txBusy`, `rxValid`, `parityErr` and `frameErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling pulse, OVERSAMPLE per bit time |
| cfgBits | input | 7 | Control word bits 21:15 (frame format and two-wire select) |
| txValid | input | 1 | A byte is offered for transmission |
| txData | input | 8 | Byte to transmit |
| txReady | output | 1 | Transmitter idle; it takes the offered byte at this edge |
| txBusy | output | 1 | A character is on the line |
| txLine | output | 1 | Serial output |
| rxLine | input | 1 | Serial input (asynchronous) |
| rxValid | output | 1 | One-cycle strobe for a received character |
| rxData | output | 8 | Received character, zero-extended |
| parityErr | output | 1 | Sticky parity fault |
| frameErr | output | 1 | Sticky framing fault |
| errClear | input | 1 | Clears both fault flags |
| flowCtlEn | output | 1 | Hardware flow control enable, passed through |

## Verification
Each transmit bit changes on `txLine` one cycle after the internal state moves. The start bit lasts between OVERSAMPLE ticks less up to one tick period and a full bit, depending on where the first tick falls. The transmit monitor therefore samples about half a bit after the observed falling edge and then exactly one bit time apart. On the receive side, the input crosses two synchronizer stages before edge detection. `rxValid`, `rxData` and `frameErr` all update one cycle after the stop-bit sample, which lies in the middle third of the stop bit. `parityErr` updates one cycle after the parity sample. The bench therefore reads the flags only after the driven frame and its idle gap have ended, and it counts the `txBusy` length from the first cycle after the accepting edge. Every sample is taken on the falling clock edge.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  // Decoded frame format
  typedef struct packed {
    logic [3:0] dataBits;
    logic       parEn;
    logic       parOdd;
    logic       twoStop;
    logic       twoWire;
  } frameCfgT;

  // What the transmit line driver puts out
  typedef enum logic [1:0] {
    LINE_HIGH = 2'd0,
    LINE_LOW  = 2'd1,
    LINE_DATA = 2'd2,
    LINE_PAR  = 2'd3
  } lineSelT;

  typedef enum logic [2:0] {
    T_IDLE, T_START, T_DATA, T_PAR, T_STOP
  } txStateT;

  typedef enum logic [2:0] {
    R_IDLE, R_START, R_DATA, R_PAR, R_STOP
  } rxStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic    txLoad;
    logic    txShift;
    lineSelT txSel;
    logic    rxClear;
    logic    rxShift;
    logic    rxParChk;
    logic    rxStopChk;
  } strobeT;

  // Field positions inside control bits 21:15
  function automatic frameCfgT decodeCfg(input logic [21:15] f);
    frameCfgT c;
    c.dataBits = 4'd8 - {2'b00, f[21:20]};
    c.parEn    = f[19];
    c.parOdd   = f[18];
    c.twoStop  = (f[17:16] == 2'b01);
    c.twoWire  = f[15];
    return c;
  endfunction

  function automatic logic [7:0] widthMask(input logic [3:0] n);
    return 8'hFF >> (4'd8 - n);
  endfunction

endpackage

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
#(
  parameter int OVERSAMPLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] dataBits,
  input  logic       parEn,
  input  logic       twoStop,
  input  logic       txValid,
  output logic       txReady,
  output logic       txBusy,
  input  logic       rxSync,
  input  logic       rxFall,
  output strobeT     strb
);

  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);

  txStateT          txState;
  logic [CNT_W-1:0] txCnt;
  logic [2:0]       txIdx;
  logic             txStop2;

  rxStateT          rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [2:0]       rxIdx;

  logic txBitEnd, txLastData, rxSamp, rxLastData;

  assign txBitEnd   = (txState != T_IDLE) && tick && (txCnt == CNT_LAST);
  assign txLastData = ({1'b0, txIdx} == (dataBits - 4'd1));
  assign rxSamp     = (rxState != R_IDLE) && tick && (rxCnt == CNT_MID);
  assign rxLastData = ({1'b0, rxIdx} == (dataBits - 4'd1));

  assign txReady = (txState == T_IDLE);
  assign txBusy  = (txState != T_IDLE);

  // Transmit sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txState <= T_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
      txStop2 <= 1'b0;
    end else if (txState == T_IDLE) begin
      if (txValid) begin
        txState <= T_START;
        txCnt   <= '0;
        txIdx   <= '0;
        txStop2 <= 1'b0;
      end
    end else if (tick) begin
      if (txCnt != CNT_LAST) begin
        txCnt <= txCnt + 1'b1;
      end else begin
        txCnt <= '0;
        unique case (txState)
          T_START: txState <= T_DATA;
          T_DATA: begin
            if (txLastData) txState <= parEn ? T_PAR : T_STOP;
            else            txIdx   <= txIdx + 3'd1;
          end
          T_PAR: txState <= T_STOP;
          T_STOP: begin
            if (twoStop && !txStop2) txStop2 <= 1'b1;
            else begin
              txStop2 <= 1'b0;
              txState <= T_IDLE;
            end
          end
          default: txState <= T_IDLE;
        endcase
      end
    end
  end

  // Receive sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxState <= R_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else if (rxState == R_IDLE) begin
      if (rxFall) begin
        rxState <= R_START;
        rxCnt   <= '0;
        rxIdx   <= '0;
      end
    end else if (tick) begin
      rxCnt <= (rxCnt == CNT_LAST) ? '0 : rxCnt + 1'b1;
      if (rxSamp) begin
        unique case (rxState)
          R_START: rxState <= rxSync ? R_IDLE : R_DATA;
          R_DATA: begin
            if (rxLastData) rxState <= parEn ? R_PAR : R_STOP;
            else            rxIdx   <= rxIdx + 3'd1;
          end
          R_PAR:   rxState <= R_STOP;
          R_STOP:  rxState <= R_IDLE;
          default: rxState <= R_IDLE;
        endcase
      end
    end
  end

  // Strobes for the datapath
  always_comb begin
    strb           = '0;
    strb.txLoad    = (txState == T_IDLE) && txValid;
    strb.txShift   = txBitEnd && (txState == T_DATA);
    unique case (txState)
      T_START: strb.txSel = LINE_LOW;
      T_DATA:  strb.txSel = LINE_DATA;
      T_PAR:   strb.txSel = LINE_PAR;
      default: strb.txSel = LINE_HIGH;
    endcase
    strb.rxClear   = (rxState == R_IDLE) && rxFall;
    strb.rxShift   = rxSamp && (rxState == R_DATA);
    strb.rxParChk  = rxSamp && (rxState == R_PAR);
    strb.rxStopChk = rxSamp && (rxState == R_STOP);
  end

endmodule

// File: rtl/uart_fe_dp.sv
module uart_fe_dp
  import uart_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dataBits,
  input  logic       parOdd,
  input  strobeT     strb,
  input  logic [7:0] txData,
  output logic       txLine,
  input  logic       rxLine,
  output logic       rxSync,
  output logic       rxFall,
  input  logic       errClear,
  output logic       rxValid,
  output logic [7:0] rxData,
  output logic       parityErr,
  output logic       frameErr
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrevQ;
  logic [7:0]             txShQ, rxShQ, txMasked;
  logic                   txParQ, txLineQ, parMismatch;

  assign txMasked    = txData & widthMask(dataBits);
  assign rxSync      = syncQ[SYNC_STAGES-1];
  assign rxFall      = rxPrevQ && !rxSync;
  assign parMismatch = (^rxShQ) ^ rxSync ^ parOdd;
  assign txLine      = txLineQ;

  // Input synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ   <= '1;
      rxPrevQ <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], rxLine};
      rxPrevQ <= rxSync;
    end
  end

  // Transmit shifter and line register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShQ   <= '0;
      txParQ  <= 1'b0;
      txLineQ <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txShQ  <= txMasked;
        txParQ <= (^txMasked) ^ parOdd;
      end else if (strb.txShift) begin
        txShQ <= txShQ >> 1;
      end
      unique case (strb.txSel)
        LINE_LOW:  txLineQ <= 1'b0;
        LINE_DATA: txLineQ <= txShQ[0];
        LINE_PAR:  txLineQ <= txParQ;
        default:   txLineQ <= 1'b1;
      endcase
    end
  end

  // Receive shifter, delivery and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShQ     <= '0;
      rxValid   <= 1'b0;
      rxData    <= '0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      if (strb.rxClear)      rxShQ <= '0;
      else if (strb.rxShift) rxShQ <= {rxSync, rxShQ[7:1]};

      rxValid <= strb.rxStopChk;
      if (strb.rxStopChk) rxData <= rxShQ >> (4'd8 - dataBits);

      if (strb.rxParChk && parMismatch) parityErr <= 1'b1;
      else if (errClear)                parityErr <= 1'b0;

      if (strb.rxStopChk && !rxSync) frameErr <= 1'b1;
      else if (errClear)             frameErr <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int OVERSAMPLE  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [21:15] cfgBits,
  input  logic         txValid,
  input  logic [7:0]   txData,
  output logic         txReady,
  output logic         txBusy,
  output logic         txLine,
  input  logic         rxLine,
  output logic         rxValid,
  output logic [7:0]   rxData,
  output logic         parityErr,
  output logic         frameErr,
  input  logic         errClear,
  output logic         flowCtlEn
);

  frameCfgT cfg;
  strobeT   strb;
  logic     rxSync, rxFall;

  assign cfg       = decodeCfg(cfgBits);
  assign flowCtlEn = !cfg.twoWire;

  uart_fe_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .dataBits (cfg.dataBits),
    .parEn    (cfg.parEn),
    .twoStop  (cfg.twoStop),
    .txValid  (txValid),
    .txReady  (txReady),
    .txBusy   (txBusy),
    .rxSync   (rxSync),
    .rxFall   (rxFall),
    .strb     (strb)
  );

  uart_fe_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dataBits  (cfg.dataBits),
    .parOdd    (cfg.parOdd),
    .strb      (strb),
    .txData    (txData),
    .txLine    (txLine),
    .rxLine    (rxLine),
    .rxSync    (rxSync),
    .rxFall    (rxFall),
    .errClear  (errClear),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .parityErr (parityErr),
    .frameErr  (frameErr)
  );

endmodule

// File: rtl/uart_fe_checker.sv
module uart_fe_checker (
  input logic clk,
  input logic rst_n,
  input logic txValid,
  input logic txReady,
  input logic txBusy,
  input logic txLine,
  input logic rxValid,
  input logic parityErr,
  input logic frameErr,
  input logic errClear
);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |=> (txBusy && !txReady)); // R6

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!txBusy && $past(!txBusy)) |-> txLine); // R4

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid); // R8

  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (parityErr && !errClear) |=> parityErr); // R9

  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frameErr && !errClear) |=> frameErr); // R10

  AST_CLEAR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    errClear |=> (!frameErr || rxValid)); // R11

endmodule

bind uart_frame_engine uart_fe_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txValid   (txValid),
  .txReady   (txReady),
  .txBusy    (txBusy),
  .txLine    (txLine),
  .rxValid   (rxValid),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .errClear  (errClear)
);

// File: tb/tb_uart_frame_engine.sv
`timescale 1ns/1ps
module tb_uart_frame_engine;

  localparam int OS     = 4;
  localparam int TDIV   = 3;
  localparam int BITCYC = OS * TDIV;

  typedef struct {
    logic [7:0] d;
    int         n;
    bit         pe;
    bit         po;
    int         stops;
  } txItemT;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic [21:15] cfgBits = '0;
  logic        txValid = 0, rxLine = 1, errClear = 0;
  logic [7:0]  txData = '0;
  logic        txReady, txBusy, txLine, rxValid, parityErr, frameErr, flowCtlEn;
  logic [7:0]  rxData;

  int vecs = 0, errs = 0, cycles = 0;
  int curN = 8, curStops = 1;
  bit curPe = 0, curPo = 0;
  int txSent = 0, txDone = 0, rxCount = 0;
  bit finished = 0;
  int tdc = 0;
  txItemT     txQ[$];
  logic [7:0] rxQ[$];

  uart_frame_engine #(.OVERSAMPLE(OS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfgBits(cfgBits),
    .txValid(txValid), .txData(txData), .txReady(txReady), .txBusy(txBusy),
    .txLine(txLine), .rxLine(rxLine), .rxValid(rxValid), .rxData(rxData),
    .parityErr(parityErr), .frameErr(frameErr), .errClear(errClear),
    .flowCtlEn(flowCtlEn)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdc  <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    tick <= (tdc == TDIV - 1);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errs++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
      summary();
    end
  end

  task automatic setFmt(input int lenCode, input bit pe, input bit po,
                        input int stopCode, input bit tw);
    cfgBits  = {lenCode[1:0], pe, po, stopCode[1:0], tw};
    curN     = 8 - lenCode;
    curPe    = pe;
    curPo    = po;
    curStops = (stopCode == 1) ? 2 : 1;
  endtask

  function automatic logic [7:0] maskN(input int n);
    return 8'hFF >> (8 - n);
  endfunction

  // Driver: offer one byte, push the expected frame at acceptance
  task automatic txSend(input logic [7:0] d);
    txItemT it;
    @(negedge clk);
    txValid = 1;
    txData  = d;
    while (!txReady) @(negedge clk);
    it.d = d; it.n = curN; it.pe = curPe; it.po = curPo; it.stops = curStops;
    txQ.push_back(it);
    txSent++;
    @(negedge clk);
    txValid = 0;
    chk(!txReady && txBusy, "R5", "ready low after accept", {txReady, txBusy}, 2'b01);
  endtask

  task automatic txWait();
    while (txDone != txSent || txBusy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: decode txLine and compare against the expected queue
  initial begin
    logic prev;
    prev = 1;
    forever begin
      @(negedge clk);
      if (prev && !txLine) begin
        txItemT it;
        logic [15:0] expB, actB, m;
        int L, k;
        repeat (5) @(negedge clk);
        if (txQ.size() == 0) begin
          chk(0, "R4", "unexpected tx frame", 0, 1);
        end else begin
          it = txQ.pop_front();
          L = 1 + it.n + (it.pe ? 1 : 0) + it.stops;
          expB = '0;
          for (int i = 0; i < it.n; i++) expB[1 + i] = it.d[i];
          k = 1 + it.n;
          if (it.pe) begin
            expB[k] = (^(it.d & maskN(it.n))) ^ it.po;
            k++;
          end
          for (int s = 0; s < it.stops; s++) expB[k + s] = 1'b1;
          actB = '0;
          actB[0] = txLine;
          for (int i = 1; i < L; i++) begin
            repeat (BITCYC) @(negedge clk);
            actB[i] = txLine;
          end
          m = 16'hFFFF >> (16 - L);
          chk((actB & m) == (expB & m), "R1 R2 R3 R4", "tx frame bits",
              int'(actB & m), int'(expB & m));
        end
        txDone++;
      end
      prev = txLine;
    end
  end

  // Driver: serialize one character onto rxLine
  task automatic rxSend(input logic [7:0] d, input bit badPar, input bit stopLvl);
    logic [7:0] md;
    md = d & maskN(curN);
    rxQ.push_back(md);
    @(negedge clk);
    rxLine = 0;
    repeat (BITCYC) @(negedge clk);
    for (int i = 0; i < curN; i++) begin
      rxLine = md[i];
      repeat (BITCYC) @(negedge clk);
    end
    if (curPe) begin
      rxLine = (^md) ^ curPo ^ badPar;
      repeat (BITCYC) @(negedge clk);
    end
    rxLine = stopLvl;
    repeat (BITCYC) @(negedge clk);
    rxLine = 1;
    repeat (BITCYC) @(negedge clk);
  endtask

  // Monitor: compare delivered characters
  initial begin
    forever begin
      @(negedge clk);
      if (rxValid) begin
        rxCount++;
        if (rxQ.size() == 0) chk(0, "R8", "unexpected rx char", rxData, 0);
        else begin
          logic [7:0] e;
          e = rxQ.pop_front();
          chk(rxData == e, "R8", "rx char", rxData, e);
        end
      end
    end
  end

  task automatic pulseClear();
    @(negedge clk);
    errClear = 1;
    @(negedge clk);
    errClear = 0;
    @(negedge clk);
  endtask

  initial begin
    int n0, busyLen, L;
    setFmt(0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(txLine === 1'b1, "R13", "txLine idle", txLine, 1);
    chk(txReady === 1'b1 && txBusy === 1'b0, "R13", "ready/busy", {txReady, txBusy}, 2'b10);
    chk(rxValid === 1'b0 && parityErr === 1'b0 && frameErr === 1'b0, "R13", "rx outputs",
        {rxValid, parityErr, frameErr}, 0);
    chk(flowCtlEn === 1'b1, "R12", "flow enable with four-wire", flowCtlEn, 1);

    // Transmit: 8N1 back-to-back
    txSend(8'hA5); txSend(8'h3C); txSend(8'hFF); txSend(8'h00);
    txWait();
    // R1 R2: 7 bits, even parity
    setFmt(1, 1, 0, 0, 0);
    txSend(8'h55); txSend(8'h7F);
    txWait();
    // R1 R2 R3: 5 bits, odd parity, two stops, back-to-back
    setFmt(3, 1, 1, 1, 0);
    txSend(8'h1A); txSend(8'hE5);
    txWait();
    // R3: 6 bits, two stops, no parity; then stop code 2 gives one stop
    setFmt(2, 0, 0, 1, 0);
    txSend(8'h2B); txSend(8'h14);
    txWait();
    setFmt(0, 0, 0, 2, 0);
    txSend(8'h96); txSend(8'h69);
    txWait();

    // R6: busy length with nothing further offered
    setFmt(0, 1, 1, 0, 0);
    txSend(8'h81);
    busyLen = 0;
    while (txBusy) begin
      busyLen++;
      @(negedge clk);
    end
    L = 11;
    chk(busyLen >= L * BITCYC - 3 && busyLen <= L * BITCYC, "R6", "busy length", busyLen, L * BITCYC);
    chk(txLine === 1'b1 && txReady === 1'b1, "R4", "idle after frame", txLine, 1);
    txWait();

    // Receive: 8N1, 7 bits, 5 bits zero-extended
    setFmt(0, 0, 0, 0, 0);
    rxSend(8'hC3, 0, 1); rxSend(8'h00, 0, 1);
    setFmt(1, 0, 0, 0, 0);
    rxSend(8'hDA, 0, 1);
    setFmt(3, 0, 0, 0, 0);
    rxSend(8'hFF, 0, 1);
    chk(!parityErr && !frameErr, "R1", "no error on clean frames", {parityErr, frameErr}, 0);

    // R9 parity error, even parity, sticky over a good frame
    setFmt(0, 1, 0, 0, 0);
    rxSend(8'h96, 1, 1);
    chk(parityErr && !frameErr, "R9", "parity error set", {parityErr, frameErr}, 2'b10);
    rxSend(8'h11, 0, 1);
    chk(parityErr === 1'b1, "R9", "parity error sticky", parityErr, 1);
    pulseClear();
    chk(!parityErr && !frameErr, "R11", "clear flags", {parityErr, frameErr}, 0);

    // R2 odd parity clean
    setFmt(0, 1, 1, 0, 0);
    rxSend(8'h07, 0, 1);
    chk(parityErr === 1'b0, "R2", "odd parity accepted", parityErr, 0);

    // R10 frame error, character still delivered
    setFmt(0, 0, 0, 0, 0);
    n0 = rxCount;
    rxSend(8'h42, 0, 0);
    chk(frameErr && !parityErr, "R10", "frame error set", {parityErr, frameErr}, 2'b01);
    chk(rxCount == n0 + 1, "R10", "char delivered on frame error", rxCount - n0, 1);
    pulseClear();
    chk(frameErr === 1'b0, "R11", "frame flag cleared", frameErr, 0);

    // R7 false start
    n0 = rxCount;
    @(negedge clk);
    rxLine = 0;
    repeat (3) @(negedge clk);
    rxLine = 1;
    repeat (4 * BITCYC) @(negedge clk);
    chk(rxCount == n0, "R7", "glitch dropped", rxCount - n0, 0);
    chk(!parityErr && !frameErr, "R7", "no flag on glitch", {parityErr, frameErr}, 0);
    rxSend(8'hE8, 0, 1);
    chk(rxCount == n0 + 1, "R7", "receiver recovers", rxCount - n0, 1);

    // R12 two-wire mode
    setFmt(0, 0, 0, 0, 1);
    @(negedge clk);
    chk(flowCtlEn === 1'b0, "R12", "flow enable in two-wire", flowCtlEn, 0);

    repeat (10) @(negedge clk);
    chk(rxQ.size() == 0, "R8", "all rx chars seen", rxQ.size(), 0);
    chk(txQ.size() == 0, "R4", "all tx frames seen", txQ.size(), 0);
    summary();
  end

endmodule